// File: doc/BRIEF.md
# On-Chip Clock Controller for Scan Test

This block decides which clock the scan flip-flops of one clock domain receive. While the scan chains are shifting, it passes a slow test clock. In functional operation it passes the fast functional clock without interruption. During a launch/capture step in test mode it holds the fast clock off and releases a counted burst of either one or two full-speed pulses. This supports at-speed testing of delay defects. One instance is placed for each asynchronous clock domain.

The two sources are never joined through a plain multiplexer. Each source has its own enable. That enable is resynchronised into the source's own clock domain and updated only while that clock is low. One source may raise its enable only after it has seen, through a synchroniser, that the other source's enable has dropped. The scan enable input is the only selector between the two sources. The capture trigger is synchronised into the fast domain. Only its rising edge starts a burst. After one burst, the controller ignores further triggers until scan enable has returned to 1.

Top module: `occ_clock_ctrl`

## Requirements
- R1: While `rst` is high (held for at least 4 cycles of the slower clock), `clk_out` stays low and both source enables are cleared.
- R2: With `scan_en` held at 1, `clk_out` follows `tclk` within a few cycles: exactly one output pulse for every test-clock pulse, and no fast pulses.
- R3: The two source enables are never both active. Each enable changes only while its own clock is low. As a result, every high phase and every low phase of `clk_out` lasts at least half the period of the faster source.
- R4: With `test_mode`=1 and `scan_en`=0, once the fast source is selected, a rising edge of `cap_trig` releases exactly one fast pulse when `pulse_two`=0 and exactly two fast pulses when `pulse_two`=1.
- R5: After a burst, further `cap_trig` edges release no pulses until `scan_en` has been 1 again. A trigger edge that arrives while `scan_en`=1 is also ignored.
- R6: With `test_mode`=0 and `scan_en`=0, `clk_out` follows `fclk` on every cycle, and `cap_trig` has no effect.
- R7: Setting `scan_en` to 1 overrides functional mode and capture mode and returns `clk_out` to the test clock. If `scan_en` rises at the same instant as `cap_trig`, no fast pulse is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Fast functional clock |
| tclk | input | 1 | Slow test clock used for shifting |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| scan_en | input | 1 | 1 selects the test clock, 0 selects the fast source |
| test_mode | input | 1 | 1 gates the fast clock for counted bursts, 0 passes it freely; changed only while `scan_en`=1 |
| cap_trig | input | 1 | Asynchronous capture trigger; its rising edge starts a burst |
| pulse_two | input | 1 | Burst length select: 0 gives one pulse, 1 gives two |
| clk_out | output | 1 | Gated clock delivered to the scan flip-flops |

## Verification
Two functions can fall in the same fast-clock cycle: the return to shift when `scan_en` rises, and the start of a burst when a synchronised trigger edge arrives. The bench arms capture mode, then drives `scan_en` and `cap_trig` high at the same instant. Two synchronisers of equal depth carry these inputs, so both edges reach the burst logic together. The result passes if no fast-width pulse appears on `clk_out`, test-clock pulses resume, and a monitor that times every high and low phase of the output records no phase shorter than half a fast period.

// File: rtl/occ_pkg.sv
`timescale 1ns/1ps
package occ_pkg;

  // Burst sequencer states in the fast domain
  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,  // waiting for a synchronised trigger edge
    BST_RUN  = 2'd1,  // fast pulses being released
    BST_DONE = 2'd2   // burst spent, waiting for scan enable to return
  } bst_state_t;

endpackage

// File: rtl/occ_sync.sv
`timescale 1ns/1ps
module occ_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/occ_src_gate.sv
`timescale 1ns/1ps
module occ_src_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic want_a,      // request for this source, asynchronous
  input  logic other_on_a,  // enable of the opposite source, asynchronous
  output logic gate_on
);

  logic want_s;
  logic other_s;

  occ_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({want_a, other_on_a}),
    .q   ({want_s, other_s})
  );

  // Updated on the falling edge so the enable only moves while clk is low
  always_ff @(negedge clk) begin
    if (rst) gate_on <= 1'b0;
    else     gate_on <= want_s & ~other_s;
  end

endmodule

// File: rtl/occ_burst.sv
`timescale 1ns/1ps
module occ_burst
  import occ_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_N     = 1,
  parameter int LONG_N      = 2
) (
  input  logic fclk,
  input  logic rst,
  input  logic scan_en,
  input  logic test_mode,
  input  logic cap_trig,
  input  logic pulse_two,
  input  logic f_on,
  output logic pass_q
);

  localparam int            CW      = $clog2(LONG_N + 1);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_N);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_N);
  localparam logic [CW-1:0] ONE_L   = CW'(1);

  logic       sen_f, tm_f, trg_s, two_s;
  logic       trg_d;
  logic       trg_rise;
  bst_state_t st;
  logic [CW-1:0] left;

  occ_sync #(.STAGES(SYNC_STAGES), .WIDTH(4)) u_sync (
    .clk (fclk),
    .rst (rst),
    .d   ({scan_en, test_mode, cap_trig, pulse_two}),
    .q   ({sen_f, tm_f, trg_s, two_s})
  );

  always_ff @(posedge fclk) begin
    if (rst) trg_d <= 1'b0;
    else     trg_d <= trg_s;
  end

  assign trg_rise = trg_s & ~trg_d;

  always_ff @(posedge fclk) begin
    if (rst) begin
      st   <= BST_IDLE;
      left <= '0;
    end else begin
      unique case (st)
        BST_IDLE: begin
          if (trg_rise && tm_f && !sen_f && f_on) begin
            st   <= BST_RUN;
            left <= two_s ? LONG_L : SHORT_L;
          end
        end
        BST_RUN: begin
          if (sen_f) begin
            st   <= BST_IDLE;
            left <= '0;
          end else if (pass_q) begin
            // this rising edge was a released pulse
            left <= left - ONE_L;
            if (left == ONE_L) st <= BST_DONE;
          end
        end
        BST_DONE: begin
          if (sen_f) st <= BST_IDLE;
        end
        default: st <= BST_IDLE;
      endcase
    end
  end

  // Gate for the fast source, changed only while fclk is low
  always_ff @(negedge fclk) begin
    if (rst) pass_q <= 1'b0;
    else     pass_q <= !tm_f || (st == BST_RUN && left != '0 && !sen_f);
  end

endmodule

// File: rtl/occ_clock_ctrl.sv
`timescale 1ns/1ps
module occ_clock_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_N     = 1,
  parameter int LONG_N      = 2
) (
  input  logic fclk,
  input  logic tclk,
  input  logic rst,
  input  logic scan_en,
  input  logic test_mode,
  input  logic cap_trig,
  input  logic pulse_two,
  output logic clk_out
);

  logic t_on;
  logic f_on;
  logic f_pass;
  logic f_gate;
  logic scan_lo;

  assign scan_lo = ~scan_en;

  occ_src_gate #(.SYNC_STAGES(SYNC_STAGES)) u_tgate (
    .clk        (tclk),
    .rst        (rst),
    .want_a     (scan_en),
    .other_on_a (f_on),
    .gate_on    (t_on)
  );

  occ_src_gate #(.SYNC_STAGES(SYNC_STAGES)) u_fgate (
    .clk        (fclk),
    .rst        (rst),
    .want_a     (scan_lo),
    .other_on_a (t_on),
    .gate_on    (f_on)
  );

  occ_burst #(
    .SYNC_STAGES (SYNC_STAGES),
    .SHORT_N     (SHORT_N),
    .LONG_N      (LONG_N)
  ) u_burst (
    .fclk      (fclk),
    .rst       (rst),
    .scan_en   (scan_en),
    .test_mode (test_mode),
    .cap_trig  (cap_trig),
    .pulse_two (pulse_two),
    .f_on      (f_on),
    .pass_q    (f_pass)
  );

  assign f_gate  = f_on & f_pass;
  assign clk_out = (fclk & f_gate) | (tclk & t_on);

endmodule

// File: rtl/occ_clock_ctrl_chk.sv
`timescale 1ns/1ps
module occ_clock_ctrl_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int LONG_N      = 2
) (
  input logic fclk,
  input logic tclk,
  input logic rst,
  input logic scan_en,
  input logic test_mode,
  input logic t_on,
  input logic f_on,
  input logic f_gate
);

  localparam int HW = SYNC_STAGES + 2;

  logic [HW-1:0] sen_hist;
  logic [3:0]    gcnt;

  always_ff @(posedge tclk) begin
    if (rst) sen_hist <= '0;
    else     sen_hist <= {sen_hist[HW-2:0], scan_en};
  end

  always_ff @(posedge fclk) begin
    if (rst || scan_en)                           gcnt <= '0;
    else if (f_gate && test_mode && gcnt != 4'hF) gcnt <= gcnt + 4'd1;
  end

  // R3
  excl_fast_chk: assert property (@(posedge fclk) disable iff (rst) !(f_on && t_on));

  // R3
  excl_slow_chk: assert property (@(posedge tclk) disable iff (rst) !(f_on && t_on));

  // R2
  shift_src_chk: assert property (@(posedge tclk) disable iff (rst) t_on |-> (sen_hist != '0));

  // R4
  burst_cap_chk: assert property (@(posedge fclk) disable iff (rst)
    (f_gate && test_mode && !scan_en) |-> (int'(gcnt) < LONG_N));

  // R6
  func_pass_chk: assert property (@(posedge fclk) disable iff (rst)
    (f_on && !test_mode) |-> f_gate);

endmodule

bind occ_clock_ctrl occ_clock_ctrl_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .LONG_N      (LONG_N)
) u_chk (
  .fclk      (fclk),
  .tclk      (tclk),
  .rst       (rst),
  .scan_en   (scan_en),
  .test_mode (test_mode),
  .t_on      (t_on),
  .f_on      (f_on),
  .f_gate    (f_gate)
);

// File: tb/tb_occ_clock_ctrl.sv
`timescale 1ns/1ps
module tb_occ_clock_ctrl;

  logic fclk = 1'b0;
  logic tclk = 1'b0;
  logic rst, scan_en, test_mode, cap_trig, pulse_two;
  logic clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // pulse monitor
  bit      mon_en = 1'b0;
  bit      seen_fall = 1'b0;
  realtime t_rise = 0.0;
  realtime t_fall = 0.0;
  int      fast_n = 0;
  int      slow_n = 0;
  int      runt_n = 0;

  occ_clock_ctrl dut (
    .fclk      (fclk),
    .tclk      (tclk),
    .rst       (rst),
    .scan_en   (scan_en),
    .test_mode (test_mode),
    .cap_trig  (cap_trig),
    .pulse_two (pulse_two),
    .clk_out   (clk_out)
  );

  always #10 fclk = ~fclk;          // 50 MHz functional clock
  initial begin
    #3;
    forever #35 tclk = ~tclk;       // slow, unrelated test clock
  end

  always @(posedge clk_out) begin
    if (mon_en) begin
      if (seen_fall && ($realtime - t_fall) < 9.5) runt_n++;
      t_rise = $realtime;
    end
  end

  always @(negedge clk_out) begin
    if (mon_en) begin
      realtime w;
      w = $realtime - t_rise;
      if (w < 9.5)                runt_n++;
      else if (w < 15.0)          fast_n++;
      else if (w > 30.0 && w < 40.0) slow_n++;
      else                        runt_n++;
      t_fall    = $realtime;
      seen_fall = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_slow(input int n, output int f_d, output int s_d);
    int f0, s0;
    @(negedge tclk); #1;
    f0 = fast_n; s0 = slow_n;
    repeat (n) @(negedge tclk);
    #1;
    f_d = fast_n - f0; s_d = slow_n - s0;
  endtask

  task automatic count_fast(input int n, output int f_d, output int s_d);
    int f0, s0;
    @(negedge fclk); #1;
    f0 = fast_n; s0 = slow_n;
    repeat (n) @(negedge fclk);
    #1;
    f_d = fast_n - f0; s_d = slow_n - s0;
  endtask

  task automatic t_reset();
    int bad = 0;
    rst = 1'b1; scan_en = 1'b1; test_mode = 1'b0; cap_trig = 1'b0; pulse_two = 1'b0;
    repeat (4) @(posedge tclk);
    for (int i = 0; i < 12; i++) begin
      #13;
      if (clk_out !== 1'b0) bad++;
    end
    // R1: output held low during reset
    chk(bad == 0, "R1", "clk_out nonzero samples in reset", bad, 0);
    mon_en = 1'b1;
    @(negedge tclk);
    rst = 1'b0;
  endtask

  task automatic t_shift();
    int fd, sd, bad = 0;
    repeat (8) @(posedge tclk);
    count_slow(20, fd, sd);
    // R2: one output pulse per test-clock pulse
    chk(sd == 20, "R2", "slow pulses in 20 tclk", sd, 20);
    chk(fd == 0, "R2", "fast pulses while shifting", fd, 0);
    for (int i = 0; i < 5; i++) begin
      @(posedge tclk); #10;
      if (clk_out !== 1'b1) bad++;
      @(negedge tclk); #10;
      if (clk_out !== 1'b0) bad++;
    end
    chk(bad == 0, "R2", "clk_out mismatches tclk", bad, 0);
  endtask

  task automatic t_capture(input bit two);
    int f0, s0, exp_n;
    exp_n = two ? 2 : 1;
    test_mode = 1'b1;
    pulse_two = two;
    repeat (3) @(posedge tclk);
    @(negedge tclk); #1;
    scan_en = 1'b0;
    #800;
    f0 = fast_n; s0 = slow_n;
    cap_trig = 1'b1;
    #600;
    // R4: counted burst length
    chk(fast_n - f0 == exp_n, "R4", "fast pulses in burst", fast_n - f0, exp_n);
    chk(slow_n - s0 == 0, "R4", "slow pulses during capture", slow_n - s0, 0);
    cap_trig = 1'b0;
    #200;
    f0 = fast_n;
    cap_trig = 1'b1;
    #600;
    // R5: retrigger without return to shift is ignored
    chk(fast_n - f0 == 0, "R5", "fast pulses on second trigger", fast_n - f0, 0);
    cap_trig = 1'b0;
    scan_en  = 1'b1;
    #800;
  endtask

  task automatic t_early_trigger();
    int f0;
    test_mode = 1'b1;
    cap_trig  = 1'b1;
    #300;
    f0 = fast_n;
    scan_en = 1'b0;
    #1200;
    // R5: trigger edge seen during shift does not fire later
    chk(fast_n - f0 == 0, "R5", "fast pulses after early trigger", fast_n - f0, 0);
    cap_trig = 1'b0;
    scan_en  = 1'b1;
    #800;
  endtask

  task automatic t_functional();
    int f0, s0, bad = 0;
    test_mode = 1'b0;
    #300;
    scan_en = 1'b0;
    #800;
    @(negedge fclk); #1;
    f0 = fast_n; s0 = slow_n;
    cap_trig = 1'b1;
    repeat (20) @(negedge fclk);
    #1;
    cap_trig = 1'b0;
    repeat (20) @(negedge fclk);
    #1;
    // R6: free-running fast clock, trigger has no effect
    chk(fast_n - f0 == 40, "R6", "fast pulses in 40 fclk", fast_n - f0, 40);
    chk(slow_n - s0 == 0, "R6", "slow pulses in functional mode", slow_n - s0, 0);
    for (int i = 0; i < 5; i++) begin
      @(posedge fclk); #5;
      if (clk_out !== 1'b1) bad++;
      @(negedge fclk); #5;
      if (clk_out !== 1'b0) bad++;
    end
    chk(bad == 0, "R6", "clk_out mismatches fclk", bad, 0);
  endtask

  task automatic t_override();
    int fd, sd;
    scan_en = 1'b1;
    #1000;
    count_slow(10, fd, sd);
    // R7: scan enable takes the output back to the test clock
    chk(sd == 10, "R7", "slow pulses after override", sd, 10);
    chk(fd == 0, "R7", "fast pulses after override", fd, 0);
  endtask

  task automatic t_collide();
    int f0, s0;
    test_mode = 1'b1;
    pulse_two = 1'b1;
    #300;
    @(negedge tclk); #1;
    scan_en = 1'b0;
    #800;
    f0 = fast_n; s0 = slow_n;
    @(negedge fclk); #3;
    scan_en  = 1'b1;   // R7: both edges in the same instant
    cap_trig = 1'b1;
    #1000;
    chk(fast_n - f0 == 0, "R7", "fast pulses on collision", fast_n - f0, 0);
    chk(slow_n - s0 >= 8, "R7", "slow pulses after collision", slow_n - s0, 8);
    cap_trig = 1'b0;
    #300;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    t_reset();
    t_shift();
    t_capture(1'b0);
    t_capture(1'b1);
    t_early_trigger();
    // R3: no short phase through all switching so far
    chk(runt_n == 0, "R3", "short phases before functional", runt_n, 0);
    t_functional();
    t_override();
    t_collide();
    // R3: no short phase anywhere in the run
    chk(runt_n == 0, "R3", "short phases total", runt_n, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule